// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block moves a synchronous DRAM into and out of its low-power states. It drives the clock-enable pin and the four command strobes (chip select, row strobe, column strobe, write enable). It takes requests to enter ordinary power-down, to enter deep power-down and to leave either state. Two status inputs gate those requests: one says an access is in flight and one says a bank has an open row. The only commands it emits are NOP, command inhibit and the deep power-down encoding. Refresh generation, bank tracking and data movement stay in neighbouring logic.

Ordinary power-down comes in two kinds. It is precharge power-down when every bank is idle at entry and active power-down when some row is open. The device gets no refresh while powered down, so a residency timer caps each stay. The timer is sized from the clock frequency, the refresh interval and a safety margin. When the cap is reached the block leaves power-down on its own and pulses a wake flag to the refresh logic. Deep power-down discards the array contents, so it is only allowed with all banks idle. A deep request made while a row is open is refused and flagged.

Top module: `sdram_pd_ctrl`

## Requirements
- R1: While and just after reset, cke is 1, the command pins show inhibit ({cs_n,ras_n,cas_n,we_n} = 4'b1111), mode is 0 (normal), ready is 1, and dpd_reject and refresh_wake are 0.
- R2: A power-down request in normal mode, with ready high, access_busy low and bank_open low, gives cke 0 with a NOP (4'b0111) on the next cycle and mode 1 (precharge power-down). On later cycles the pins show inhibit while cke stays 0.
- R3: The same request with bank_open high gives mode 2 (active power-down), with cke 0 and a NOP on the next cycle.
- R4: Power-down and deep power-down requests made while access_busy is high are ignored: cke, the command pins and mode do not change.
- R5: An exit request in mode 1, 2 or 3 gives cke 1 with a NOP and mode 0 on the next cycle.
- R6: ready is 0 throughout any power-down state and in the cycle of the exit NOP, and it returns to 1 on the cycle after.
- R7: An ordinary power-down state holds cke at 0 for at most LIMIT = CLK_MHZ*REFRESH_US - MARGIN_CYCLES cycles. When that many cycles have passed without an exit request, the block exits by itself and drives refresh_wake to 1 for exactly the exit cycle.
- R8: A deep power-down request with all banks idle gives cke 0 with the encoding 4'b0110 and mode 3 on the next cycle. After that, cke stays 0 with inhibit on the pins until an exit request, and the residency cap does not end it.
- R9: A deep power-down request while bank_open is high pulses dpd_reject for one cycle. Mode stays 0, cke stays 1 and the pins stay at inhibit.
- R10: An exit request in normal mode has no effect. An entry request while in a power-down state has no effect.
- R11: When both entry requests arrive together, the deep request wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Request to enter ordinary power-down |
| dpd_req | input | 1 | Request to enter deep power-down |
| exit_req | input | 1 | Request to leave the current low-power state |
| access_busy | input | 1 | An access is in progress, so entry is not allowed |
| bank_open | input | 1 | At least one bank has an open row |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| mode | output | 2 | 0 normal, 1 precharge PD, 2 active PD, 3 deep PD |
| ready | output | 1 | The controller may issue a new command |
| dpd_reject | output | 1 | One-cycle pulse when a deep request is refused |
| refresh_wake | output | 1 | One-cycle pulse when the residency cap forces an exit |

## Verification
The bench builds the block with CLK_MHZ=1, REFRESH_US=40 and MARGIN_CYCLES=8, so the residency cap is 32 cycles. With such a small cap, a forced exit can be timed to the exact cycle. The same test can also hold a deep power-down well past the cap and show that it never ends on its own. At the default of 100 MHz the cap is millions of cycles, which a directed run could not reach.

// File: rtl/sdram_pd_pkg.sv
package sdram_pd_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL  = 2'd0,
        MODE_PRE_PD  = 2'd1,
        MODE_ACT_PD  = 2'd2,
        MODE_DEEP_PD = 2'd3
    } pd_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ENTER_PD,
        ACT_ENTER_DPD,
        ACT_EXIT
    } pd_action_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t CMD_INHIBIT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t CMD_NOP     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_pins_t CMD_DPD     = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b0};

    function automatic logic is_light_pd(input pd_mode_e m);
        return (m == MODE_PRE_PD) || (m == MODE_ACT_PD);
    endfunction

    function automatic int unsigned residency_limit(input int unsigned mhz,
                                                    input int unsigned us,
                                                    input int unsigned margin);
        return mhz * us - margin;
    endfunction

endpackage

// File: rtl/pd_residency_timer.sv
module pd_residency_timer #(
    parameter int unsigned LIMIT = 32,
    parameter int unsigned CNT_W = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic in_pd,
    output logic limit_hit
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (in_pd) begin
            count <= count + 1'b1;
        end else begin
            count <= '0;
        end
    end

    assign limit_hit = in_pd && (count == CNT_W'(LIMIT - 1));

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        in_pd |-> (count < CNT_W'(LIMIT)));

endmodule

// File: rtl/pd_mode_fsm.sv
module pd_mode_fsm
    import sdram_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_req,
    input  logic       dpd_req,
    input  logic       exit_req,
    input  logic       access_busy,
    input  logic       bank_open,
    input  logic       limit_hit,
    output pd_mode_e   mode,
    output pd_action_e action,
    output logic       ready,
    output logic       dpd_reject,
    output logic       refresh_wake
);
    pd_mode_e mode_nxt;
    logic     reject_nxt;

    always_comb begin
        action     = ACT_NONE;
        reject_nxt = 1'b0;
        unique case (mode)
            MODE_NORMAL: begin
                if (ready && !access_busy) begin
                    if (dpd_req) begin
                        if (bank_open) reject_nxt = 1'b1;
                        else           action     = ACT_ENTER_DPD;
                    end else if (pd_req) begin
                        action = ACT_ENTER_PD;
                    end
                end
            end
            MODE_PRE_PD, MODE_ACT_PD: begin
                if (exit_req || limit_hit) action = ACT_EXIT;
            end
            MODE_DEEP_PD: begin
                if (exit_req) action = ACT_EXIT;
            end
            default: action = ACT_NONE;
        endcase
    end

    always_comb begin
        mode_nxt = mode;
        unique case (action)
            ACT_ENTER_PD:  mode_nxt = bank_open ? MODE_ACT_PD : MODE_PRE_PD;
            ACT_ENTER_DPD: mode_nxt = MODE_DEEP_PD;
            ACT_EXIT:      mode_nxt = MODE_NORMAL;
            default:       mode_nxt = mode;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= MODE_NORMAL;
            ready        <= 1'b1;
            dpd_reject   <= 1'b0;
            refresh_wake <= 1'b0;
        end else begin
            mode         <= mode_nxt;
            ready        <= (mode_nxt == MODE_NORMAL) && (action != ACT_EXIT);
            dpd_reject   <= reject_nxt;
            refresh_wake <= (action == ACT_EXIT) && limit_hit && is_light_pd(mode);
        end
    end

    // R9
    reject_keeps_mode_chk: assert property (@(posedge clk) disable iff (rst)
        dpd_reject |-> (mode == MODE_NORMAL) && ($past(mode) == MODE_NORMAL));

    // R6
    ready_only_normal_chk: assert property (@(posedge clk) disable iff (rst)
        ready |-> (mode == MODE_NORMAL));

endmodule

// File: rtl/pd_pin_driver.sv
module pd_pin_driver
    import sdram_pd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pd_action_e action,
    output logic       cke,
    output cmd_pins_t  cmd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cke <= 1'b1;
            cmd <= CMD_INHIBIT;
        end else begin
            unique case (action)
                ACT_ENTER_PD: begin
                    cke <= 1'b0;
                    cmd <= CMD_NOP;
                end
                ACT_ENTER_DPD: begin
                    cke <= 1'b0;
                    cmd <= CMD_DPD;
                end
                ACT_EXIT: begin
                    cke <= 1'b1;
                    cmd <= CMD_NOP;
                end
                default: begin
                    cmd <= CMD_INHIBIT;
                end
            endcase
        end
    end

    // R8
    dpd_code_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_DPD) |-> !cke);

endmodule

// File: rtl/sdram_pd_ctrl.sv
module sdram_pd_ctrl
    import sdram_pd_pkg::*;
#(
    parameter int unsigned CLK_MHZ       = 100,
    parameter int unsigned REFRESH_US    = 64000,
    parameter int unsigned MARGIN_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_req,
    input  logic       dpd_req,
    input  logic       exit_req,
    input  logic       access_busy,
    input  logic       bank_open,
    output logic       cke,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n,
    output logic [1:0] mode,
    output logic       ready,
    output logic       dpd_reject,
    output logic       refresh_wake
);
    localparam int unsigned LIMIT = residency_limit(CLK_MHZ, REFRESH_US, MARGIN_CYCLES);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    pd_mode_e   mode_q;
    pd_action_e action;
    cmd_pins_t  cmd;
    logic       limit_hit;

    pd_mode_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .pd_req       (pd_req),
        .dpd_req      (dpd_req),
        .exit_req     (exit_req),
        .access_busy  (access_busy),
        .bank_open    (bank_open),
        .limit_hit    (limit_hit),
        .mode         (mode_q),
        .action       (action),
        .ready        (ready),
        .dpd_reject   (dpd_reject),
        .refresh_wake (refresh_wake)
    );

    pd_residency_timer #(
        .LIMIT (LIMIT),
        .CNT_W (CNT_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .in_pd     (is_light_pd(mode_q)),
        .limit_hit (limit_hit)
    );

    pd_pin_driver u_pins (
        .clk    (clk),
        .rst    (rst),
        .action (action),
        .cke    (cke),
        .cmd    (cmd)
    );

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;
    assign mode  = mode_q;

    // R8
    deep_cke_low_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DEEP_PD) |-> !cke);

    // R5
    exit_with_nop_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> (cmd == CMD_NOP) && (mode_q == MODE_NORMAL));

    // R6
    exit_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke) |-> !ready);

    // R2
    entry_leaves_normal_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cke) |-> (mode_q != MODE_NORMAL) && (cmd != CMD_INHIBIT));

    // R7
    wake_on_exit_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_wake |-> $rose(cke));

endmodule

// File: tb/sim_sdram_pd_ctrl.sv
module sim_sdram_pd_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_req = 1'b0, dpd_req = 1'b0, exit_req = 1'b0;
    logic       access_busy = 1'b0, bank_open = 1'b0;
    logic       cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0] mode;
    logic       ready, dpd_reject, refresh_wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam int LIMIT = 1 * 40 - 8;
    localparam logic [3:0] P_INH = 4'b1111;
    localparam logic [3:0] P_NOP = 4'b0111;
    localparam logic [3:0] P_DPD = 4'b0110;

    always #2.5 clk = ~clk;

    sdram_pd_ctrl #(.CLK_MHZ(1), .REFRESH_US(40), .MARGIN_CYCLES(8)) u0 (
        .clk(clk), .rst(rst), .pd_req(pd_req), .dpd_req(dpd_req), .exit_req(exit_req),
        .access_busy(access_busy), .bank_open(bank_open), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .mode(mode), .ready(ready),
        .dpd_reject(dpd_reject), .refresh_wake(refresh_wake)
    );

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) tick();
        check("R1", "cke in reset", int'(cke), 1);
        check("R1", "pins in reset", int'(pins()), int'(P_INH));
        rst = 1'b0;
        tick();
        check("R1", "mode", int'(mode), 0);
        check("R1", "ready", int'(ready), 1);
        check("R1", "flags", int'({dpd_reject, refresh_wake}), 0);
    endtask

    task automatic do_exit(input string req);
        exit_req = 1'b1;
        tick();
        exit_req = 1'b0;
        check(req, "exit cke", int'(cke), 1);
        check(req, "exit pins", int'(pins()), int'(P_NOP));
        check(req, "exit mode", int'(mode), 0);
        check("R6", "ready in exit cycle", int'(ready), 0);
        tick();
        check("R6", "ready after exit", int'(ready), 1);
        check(req, "pins after exit", int'(pins()), int'(P_INH));
    endtask

    task automatic t_precharge_pd();
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        check("R2", "entry cke", int'(cke), 0);
        check("R2", "entry pins", int'(pins()), int'(P_NOP));
        check("R2", "entry mode", int'(mode), 1);
        tick();
        check("R2", "hold pins", int'(pins()), int'(P_INH));
        check("R2", "hold cke", int'(cke), 0);
        check("R6", "ready in pd", int'(ready), 0);
        do_exit("R5");
    endtask

    task automatic t_active_pd();
        bank_open = 1'b1;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        check("R3", "entry mode", int'(mode), 2);
        check("R3", "entry pins", int'(pins()), int'(P_NOP));
        check("R3", "entry cke", int'(cke), 0);
        tick();
        do_exit("R5");
        bank_open = 1'b0;
    endtask

    task automatic t_busy_ignored();
        access_busy = 1'b1;
        pd_req = 1'b1;
        tick();
        check("R4", "pd while busy cke", int'(cke), 1);
        check("R4", "pd while busy mode", int'(mode), 0);
        pd_req = 1'b0;
        dpd_req = 1'b1;
        tick();
        dpd_req = 1'b0;
        check("R4", "dpd while busy pins", int'(pins()), int'(P_INH));
        check("R4", "dpd while busy mode", int'(mode), 0);
        access_busy = 1'b0;
        tick();
    endtask

    task automatic t_residency_cap();
        int low_cycles;
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        low_cycles = 1;
        check("R7", "wake low during pd", int'(refresh_wake), 0);
        while (cke == 1'b0 && low_cycles < 3 * LIMIT) begin
            tick();
            if (cke == 1'b0) low_cycles++;
            else begin
                check("R7", "wake at forced exit", int'(refresh_wake), 1);
                check("R7", "forced exit pins", int'(pins()), int'(P_NOP));
                check("R6", "ready at forced exit", int'(ready), 0);
            end
        end
        check("R7", "cycles cke low", low_cycles, LIMIT);
        tick();
        check("R7", "wake one cycle", int'(refresh_wake), 0);
        check("R7", "mode after cap", int'(mode), 0);
    endtask

    task automatic t_deep_pd();
        dpd_req = 1'b1;
        tick();
        dpd_req = 1'b0;
        check("R8", "entry pins", int'(pins()), int'(P_DPD));
        check("R8", "entry cke", int'(cke), 0);
        check("R8", "entry mode", int'(mode), 3);
        repeat (LIMIT + 20) tick();
        check("R8", "still deep past cap", int'(mode), 3);
        check("R8", "cke held low", int'(cke), 0);
        check("R8", "pins inhibit", int'(pins()), int'(P_INH));
        check("R8", "no wake", int'(refresh_wake), 0);
        do_exit("R5");
    endtask

    task automatic t_deep_reject();
        bank_open = 1'b1;
        dpd_req = 1'b1;
        tick();
        dpd_req = 1'b0;
        check("R9", "reject pulse", int'(dpd_reject), 1);
        check("R9", "mode kept", int'(mode), 0);
        check("R9", "cke kept", int'(cke), 1);
        check("R9", "pins kept", int'(pins()), int'(P_INH));
        tick();
        check("R9", "reject one cycle", int'(dpd_reject), 0);
        bank_open = 1'b0;
    endtask

    task automatic t_ignored();
        exit_req = 1'b1;
        tick();
        exit_req = 1'b0;
        check("R10", "exit in normal pins", int'(pins()), int'(P_INH));
        check("R10", "exit in normal ready", int'(ready), 1);
        pd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        tick();
        dpd_req = 1'b1;
        tick();
        dpd_req = 1'b0;
        check("R10", "dpd in pd mode", int'(mode), 1);
        check("R10", "dpd in pd pins", int'(pins()), int'(P_INH));
        do_exit("R5");
    endtask

    task automatic t_priority();
        pd_req = 1'b1;
        dpd_req = 1'b1;
        tick();
        pd_req = 1'b0;
        dpd_req = 1'b0;
        check("R11", "both requests mode", int'(mode), 3);
        check("R11", "both requests pins", int'(pins()), int'(P_DPD));
        tick();
        do_exit("R5");
    endtask

    initial begin
        t_reset();
        t_precharge_pd();
        t_active_pd();
        t_busy_ignored();
        t_residency_cap();
        t_deep_pd();
        t_deep_reject();
        t_ignored();
        t_priority();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done == 1'b1);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule